// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block answers I2C transactions that a display driver tunnels through an auxiliary channel, where the only I2C target is an EDID ROM. The host stores a request header in the first of five data registers and then writes the control register with the send-busy bit and a message length. In the cycle of that control write the block decodes the header and updates its selection state: which port is selected, whether EDID is available there, and the ROM read pointer. It then completes the transaction at once. Control is rewritten with a done bit and a reply size, and the first data register is rewritten with the reply word.

Address-only requests (length 3) open, restart or stop a transaction. Reads (length 4) return one ROM byte per request. Write requests are acknowledged and have no other effect. For each port, inputs tell the block whether a monitor is present and whether the port carries the auxiliary channel, so EDID becomes available only on a present auxiliary-channel port. The ROM content is generated by a function of port and byte index.

Top module: `aux_edid_responder`

## Requirements
- R1: The register is selected by the 8-bit address: 0x10 is control and 0x14, 0x18, 0x1C, 0x20, 0x24 are data registers 1 to 5. A write to a data register stores the word, and reads of any of the six return the stored word. Any other address reads 0, and a write to it changes nothing.
- R2: A control write with bit 31 (send-busy) clear changes neither control, data register 1, the selection state nor the error flag.
- R3: A control write with bit 31 set rewrites control to have bit 30 (done) set and bits 24:20 holding a reply size: 2 when header bit 28 is set, otherwise 1. All other control bits are 0.
- R4: The header in data register 1 holds the I2C address in bits 23:8 and the opcode in bits 31:28. Opcode bit 0 (bit 28) means read, opcode bit 2 (bit 30) is the middle-of-transaction flag, and opcode bits 1 and 3 (bits 29 and 31) mark an unexpected opcode for reads. The message length is taken from control write bits 24:20.
- R5: A length-3 request with the middle-of-transaction flag clear is a stop. It deselects the target, marks EDID unavailable and clears the read pointer, so the next read returns 0xFF.
- R6: A length-3 request with the flag set resets state as in R5 when the address is 0. When the address is 0x0050 it selects the port given by port_sel and marks EDID available exactly when mon_present and mon_dp are both set for that port.
- R7: A well-formed read (length 4, opcode bits 1 and 3 clear) with EDID selected and available writes the ROM byte at the read pointer into bits 23:16 of data register 1 and advances the pointer. The ROM byte at index i of port p is ((2*i) mod 256) XOR ((60+33*p) mod 256). Without selection and availability those bits are 0xFF.
- R8: Every send except a malformed read writes data register 1 with the ACK code 0x00 in bits 31:24, the read byte (or 0) in bits 23:16 and 0 below. A write request (bit 28 clear, length not 3) changes nothing else.
- R9: A read with length other than 4, or with an unexpected opcode, leaves data register 1 untouched and sets err_flag, which stays set until reset.
- R10: The read pointer is 0 after every state reset. A read with the pointer at or past 128 returns 0x00 in bits 23:16 and does not move the pointer.
- R11: After reset all six registers read 0, err_flag is 0 and nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| port_sel | input | 2 | Port that owns this channel |
| mon_present | input | 4 | Monitor present, one bit per port |
| mon_dp | input | 4 | Port carries the auxiliary channel, one bit per port |
| err_flag | output | 1 | Sticky malformed-read flag |

## Verification
Every result of a write appears on the edge that takes the write, and the register file is read combinationally, so stored data, the control reply, the data-register reply and err_flag can all be read in the cycle after the write. The bench drives each write at a falling edge and updates its reference model right after the following rising edge. It then sets rd_addr at the next falling edge and compares shortly after, and it compares err_flag against the model at every falling edge. The full 128-byte walk, the reads past the end, stop and reset requests, and reads on ports without a monitor or without the auxiliary channel are each compared word for word.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

  typedef enum logic [2:0] {
    REG_CTL   = 3'd0,
    REG_DATA1 = 3'd1,
    REG_DATA2 = 3'd2,
    REG_DATA3 = 3'd3,
    REG_DATA4 = 3'd4,
    REG_DATA5 = 3'd5,
    REG_NONE  = 3'd7
  } aux_reg_e;

  typedef struct packed {
    logic        is_read;
    logic        mot;
    logic        odd_op;
    logic [15:0] i2c_addr;
  } aux_hdr_t;

  localparam int BUSY_BIT = 31;
  localparam int DONE_BIT = 30;
  localparam int LEN_LSB  = 20;
  localparam int LEN_W    = 5;
  localparam logic [LEN_W-1:0] LEN_ADDR_ONLY = 5'd3;
  localparam logic [LEN_W-1:0] LEN_READ      = 5'd4;

  // Synthetic ROM contents per port.
  function automatic logic [7:0] edid_rom_byte(input logic [7:0] port, input logic [7:0] idx);
    logic [7:0] seed;
    seed = 8'h3C + port * 8'h21;
    return {idx[6:0], 1'b0} ^ seed;
  endfunction

  function automatic logic [LEN_W-1:0] reply_size(input logic is_read);
    return is_read ? 5'd2 : 5'd1;
  endfunction

  function automatic aux_reg_e reg_of(input logic [7:0] lo);
    case (lo)
      8'h10:   return REG_CTL;
      8'h14:   return REG_DATA1;
      8'h18:   return REG_DATA2;
      8'h1C:   return REG_DATA3;
      8'h20:   return REG_DATA4;
      8'h24:   return REG_DATA5;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode
  import aux_edid_pkg::*;
(
  input  logic [7:0] addr,
  output aux_reg_e   sel
);
  assign sel = reg_of(addr);
endmodule

// File: rtl/aux_req_decode.sv
module aux_req_decode
  import aux_edid_pkg::*;
(
  input  logic [31:8] word,
  output aux_hdr_t    hdr
);
  logic [3:0] opcode;
  assign opcode       = word[31:28];
  assign hdr.is_read  = opcode[0];
  assign hdr.mot      = opcode[2];
  assign hdr.odd_op   = opcode[1] | opcode[3];
  assign hdr.i2c_addr = word[23:8];
endmodule

// File: rtl/aux_edid_state.sv
module aux_edid_state
  import aux_edid_pkg::*;
#(
  parameter int          NPORTS    = 4,
  parameter int          ROM_BYTES = 128,
  parameter logic [15:0] EDID_ADDR = 16'h0050,
  parameter logic [7:0]  ACK_CODE  = 8'h00,
  localparam int         PORT_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int         PTR_W     = $clog2(ROM_BYTES + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_fire,
  input  aux_hdr_t          hdr,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [NPORTS-1:0] mon_present,
  input  logic [NPORTS-1:0] mon_dp,
  output logic [31:0]       reply_word,
  output logic              reply_we,
  output logic              malformed,
  output logic              err_flag
);
  logic              sel_q, avail_q, err_q;
  logic [PORT_W-1:0] port_q;
  logic [PTR_W-1:0]  ptr_q;

  // Named events for the assertions.
  logic addr_only, do_reinit, do_select, rd_req, rd_ok, have_rom, in_range, advance;
  logic [7:0] rd_byte;

  assign addr_only = (msg_len == LEN_ADDR_ONLY);
  assign do_reinit = send_fire && addr_only && (!hdr.mot || hdr.i2c_addr == 16'h0000);
  assign do_select = send_fire && addr_only && hdr.mot && hdr.i2c_addr == EDID_ADDR;
  assign rd_req    = send_fire && !addr_only && hdr.is_read;
  assign malformed = rd_req && (msg_len != LEN_READ || hdr.odd_op);
  assign rd_ok     = rd_req && !malformed;
  assign have_rom  = sel_q && avail_q;
  assign in_range  = ptr_q < PTR_W'(ROM_BYTES);
  assign advance   = rd_ok && have_rom && in_range;

  always_comb begin
    if (!have_rom)     rd_byte = 8'hFF;
    else if (in_range) rd_byte = edid_rom_byte(8'(port_q), 8'(ptr_q));
    else               rd_byte = 8'h00;
  end

  assign reply_word = {ACK_CODE, (rd_ok ? rd_byte : 8'h00), 16'h0000};
  assign reply_we   = send_fire && !malformed;
  assign err_flag   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      port_q  <= '0;
      ptr_q   <= '0;
    end else if (do_reinit) begin
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      port_q  <= '0;
      ptr_q   <= '0;
    end else if (do_select) begin
      sel_q   <= 1'b1;
      avail_q <= mon_present[port_sel] & mon_dp[port_sel];
      port_q  <= port_sel;
    end else if (advance) begin
      ptr_q   <= PTR_W'(ptr_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (malformed) err_q <= 1'b1;
  end

  p_ptr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(ROM_BYTES));

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (send_fire && addr_only && !hdr.mot) |=> (!sel_q && !avail_q && ptr_q == '0));

  p_select_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_select |=> (sel_q && avail_q == $past(mon_present[port_sel] & mon_dp[port_sel])));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !in_range && !do_reinit) |=> $stable(ptr_q));

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
  import aux_edid_pkg::*;
#(
  parameter int          NPORTS    = 4,
  parameter int          ROM_BYTES = 128,
  parameter logic [15:0] EDID_ADDR = 16'h0050,
  parameter logic [7:0]  ACK_CODE  = 8'h00,
  localparam int         PORT_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int         N_DATA    = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [NPORTS-1:0] mon_present,
  input  logic [NPORTS-1:0] mon_dp,
  output logic              err_flag
);
  aux_reg_e    wr_reg, rd_reg;
  aux_hdr_t    hdr;
  logic [31:0] ctl_q;
  logic [31:0] data_q [N_DATA];
  logic [31:0] data1, reply_word, ctl_reply;
  logic        send_fire, idle_ctl, reply_we, malformed, req_is_read;

  aux_reg_decode u_wr_dec (.addr(wr_addr), .sel(wr_reg));
  aux_reg_decode u_rd_dec (.addr(rd_addr), .sel(rd_reg));

  assign data1 = data_q[0];
  aux_req_decode u_req (.word(data1[31:8]), .hdr(hdr));
  assign req_is_read = hdr.is_read;

  assign send_fire = wr_en && wr_reg == REG_CTL && wr_data[BUSY_BIT];
  assign idle_ctl  = wr_en && wr_reg == REG_CTL && !wr_data[BUSY_BIT];

  aux_edid_state #(
    .NPORTS(NPORTS), .ROM_BYTES(ROM_BYTES), .EDID_ADDR(EDID_ADDR), .ACK_CODE(ACK_CODE)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .send_fire(send_fire), .hdr(hdr),
    .msg_len(wr_data[LEN_LSB +: LEN_W]), .port_sel(port_sel),
    .mon_present(mon_present), .mon_dp(mon_dp),
    .reply_word(reply_word), .reply_we(reply_we),
    .malformed(malformed), .err_flag(err_flag)
  );

  always_comb begin
    ctl_reply = '0;
    ctl_reply[DONE_BIT] = 1'b1;
    ctl_reply[LEN_LSB +: LEN_W] = reply_size(hdr.is_read);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= '0;
    else if (send_fire) ctl_q <= ctl_reply;
  end

  for (genvar k = 0; k < N_DATA; k++) begin : g_data
    if (k == 0) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         data_q[k] <= '0;
        else if (reply_we)                  data_q[k] <= reply_word;
        else if (wr_en && wr_reg == REG_DATA1) data_q[k] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q[k] <= '0;
        else if (wr_en && wr_reg == aux_reg_e'(3'(k + 1))) data_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    case (rd_reg)
      REG_CTL:   rd_data = ctl_q;
      REG_DATA1: rd_data = data_q[0];
      REG_DATA2: rd_data = data_q[1];
      REG_DATA3: rd_data = data_q[2];
      REG_DATA4: rd_data = data_q[3];
      REG_DATA5: rd_data = data_q[4];
      default:   rd_data = '0;
    endcase
  end

  p_ctl_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_fire |=> (ctl_q[DONE_BIT] && ctl_q[LEN_LSB +: LEN_W] == reply_size($past(req_is_read))));

  p_idle_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ctl |=> ($stable(ctl_q) && $stable(data1)));

  p_malformed_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    malformed |=> $stable(data1));

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (send_fire && !malformed) |=> data1[31:24] == ACK_CODE);

endmodule

// File: tb/test_aux_edid_responder.sv
`timescale 1ns/1ps
module test_aux_edid_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  port_sel = 2'd0;
  logic [3:0]  mon_present = 4'b1011;
  logic [3:0]  mon_dp      = 4'b0011;
  logic        err_flag;

  int n_checks = 0, n_fail = 0;
  bit running = 1'b0;

  // Reference model state
  logic [31:0] m_ctl;
  logic [31:0] m_data [5];
  bit m_sel, m_avail, m_err;
  int m_port, m_ptr;

  always #10 clk = ~clk;

  aux_edid_responder i_aux_edid_responder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .port_sel(port_sel),
    .mon_present(mon_present), .mon_dp(mon_dp), .err_flag(err_flag)
  );

  function automatic int rom(int p, int i);
    return ((2 * i) & 255) ^ ((60 + 33 * p) & 255);
  endfunction

  task automatic m_reset_state();
    m_sel = 0; m_avail = 0; m_port = 0; m_ptr = 0;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int op, len, addr, b;
    bit rd, mot, odd;
    if (a >= 8'h14 && a <= 8'h24 && a[1:0] == 2'b00) m_data[(a - 8'h14) / 4] = d;
    if (a == 8'h10 && d[31]) begin
      op = int'(m_data[0][31:28]); len = int'(d[24:20]);
      addr = int'(m_data[0][23:8]);
      rd = op[0]; mot = op[2]; odd = (op & 4'hA) != 0;
      m_ctl = 32'h4000_0000 | ((rd ? 32'd2 : 32'd1) << 20);
      if (len == 3) begin
        if (!mot || addr == 0) m_reset_state();
        else if (addr == 16'h0050) begin
          m_sel = 1; m_port = int'(port_sel);
          m_avail = mon_present[port_sel] && mon_dp[port_sel];
        end
        m_data[0] = 32'h0;
      end else if (!rd) begin
        m_data[0] = 32'h0;
      end else if (len != 4 || odd) begin
        m_err = 1;
      end else begin
        if (m_sel && m_avail) begin
          if (m_ptr < 128) begin b = rom(m_port, m_ptr); m_ptr++; end
          else b = 0;
        end else b = 255;
        m_data[0] = 32'(b) << 16;
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_write(a, d);
    #1 wr_en = 1'b0;
  endtask

  task automatic check_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #2;
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: reg %h got %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check_reg(8'h10, m_ctl, tag);
    for (int k = 0; k < 5; k++) check_reg(8'(8'h14 + 4 * k), m_data[k], tag);
  endtask

  task automatic send(input logic [31:0] hdr, input int len, input string tag);
    wr(8'h14, hdr);
    wr(8'h10, 32'h8000_0000 | (32'(len) << 20));
    check_reg(8'h10, m_ctl, tag);
    check_reg(8'h14, m_data[0], tag);
  endtask

  // err_flag compared every cycle (R9)
  always @(negedge clk) begin
    if (running) begin
      n_checks++;
      if (err_flag !== m_err) begin
        n_fail++;
        $display("FAIL R9 err_flag: got %b expected %b", err_flag, m_err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    m_ctl = 0; m_err = 0;
    for (int k = 0; k < 5; k++) m_data[k] = 0;
    m_reset_state();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1'b1;

    // R11: reset state
    check_all("R11 reset");

    // R1: data registers store, unmapped address ignored
    wr(8'h18, 32'hA5A5_0001); wr(8'h1C, 32'h1234_5678);
    wr(8'h20, 32'hDEAD_BEEF); wr(8'h24, 32'h0F0F_F0F0);
    check_all("R1 data store");
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h11, 32'hFFFF_FFFF);
    check_reg(8'h28, 32'h0, "R1 unmapped read");
    check_all("R1 unmapped write ignored");

    // R2: control write without send-busy
    wr(8'h14, 32'h5000_5000);
    wr(8'h10, 32'h0030_0000);
    check_all("R2 idle control");

    // R7/R3: read before any selection returns 0xFF
    send(32'h5000_0000, 4, "R7 unselected read");
    // R4/R6: select port 0 (present, aux) via middle-of-transaction write header
    port_sel = 2'd0;
    send(32'h4000_5000, 3, "R6 select port0");
    for (int i = 0; i < 3; i++) send(32'h5000_0000, 4, "R7 rom read");
    // R8: write request only acknowledged
    send(32'h4000_0000, 4, "R8 write ack");
    send(32'h5000_0000, 4, "R8 pointer unchanged by write");
    // R9: malformed reads
    send(32'h5000_0000, 5, "R9 bad length");
    send(32'hD000_0000, 4, "R9 odd opcode bit3");
    send(32'h7000_0000, 4, "R9 odd opcode bit1");
    // R5: stop then read
    send(32'h1000_0000, 3, "R5 stop");
    send(32'h5000_0000, 4, "R5 read after stop");
    // R10: full walk from pointer 0, then past the end
    send(32'h4000_5000, 3, "R10 reselect");
    for (int i = 0; i < 130; i++) send(32'h5000_0000, 4, "R10 walk");
    // R6: address 0 reset
    send(32'h4000_0000, 3, "R6 address zero reset");
    send(32'h5000_0000, 4, "R6 read after reset");
    // R6: port 3 present but not aux, port 2 absent
    port_sel = 2'd3;
    send(32'h4000_5000, 3, "R6 select port3");
    send(32'h5000_0000, 4, "R6 port3 unavailable");
    port_sel = 2'd2;
    send(32'h4000_5000, 3, "R6 select port2");
    send(32'h5000_0000, 4, "R6 port2 absent");
    // R7: port 1 bytes
    port_sel = 2'd1;
    send(32'h4000_5000, 3, "R7 select port1");
    for (int i = 0; i < 4; i++) send(32'h5000_0000, 4, "R7 port1 read");
    // R3: address-only with read bit gives reply size 2
    send(32'h5000_5000, 3, "R3 address-only read size");
    check_all("R1 final registers");

    running = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule